// File: doc/BRIEF.md
# Pipelined Burst SRAM with Byte-Lane Writes

A synthesizable behavioural model of a synchronous static RAM with a registered input stage, a pipelined read path and a 2-bit burst counter. Every input is captured on the rising clock edge. A burst is opened by one of two start strobes. The first beat uses the external address. Later beats take their address from an internal counter, which moves forward only in cycles where the advance input is high. The counter runs in linear or interleaved order, as chosen by a mode input.

Each beat is either a read or a write. A write updates all four byte lanes when the global write input is high. Otherwise it updates only the lanes that are selected while the byte-write enable is high. Read data comes out through an output register. The shared data bus is modelled as a separate write-data input, a read-data output and a drive-enable output. The drive enable follows the output-enable input while the part is selected, and it stays on for two cycles after a deselect.

Top module: `burst_sram`

## Requirements
- R1: A start by the processor strobe (`start_cpu_i` with `ce_i` high) or by the controller strobe (`start_ctl_i` with `ce_i` high) selects the part. The first beat then accesses `addr_i` as sampled in that cycle.
- R2: `start_cpu_i` has no effect while `ce_i` is low. An open burst continues as if no strobe were present, and a deselected part stays deselected with `drive_o` low.
- R3: In a selected cycle with no start, the burst offset (beat counter) steps by one when `adv_i` is high. The beat repeats the previous address when `adv_i` is low.
- R4: When `mode_i` is 0 at the start, beat n uses low address bits (start low bits + n) mod 4. The upper address bits stay fixed.
- R5: When `mode_i` is 1 at the start, beat n uses low address bits equal to the start low bits XOR n.
- R6: When `gw_i` is high on a write beat, all four lanes are written, whatever `bwe_i` and `bw_i` are.
- R7: When `gw_i` is low, only lanes whose `bw_i` bit is set are written, and only when `bwe_i` is high. Bit k of `bw_i` selects byte k, which is bits 8k+7..8k. If `bwe_i` is low or `bw_i` is 0, nothing is written.
- R8: The beat opened by the processor strobe is always a read, whatever the write controls are. The beat opened by the controller strobe, and every continuation beat, applies the write controls of its cycle.
- R9: A read beat sampled at clock edge k drives its word on `rdata_o` after edge k+1. `rdata_o` holds its value through write beats.
- R10: `drive_o` equals `oe_i` while the part is selected. A controller strobe with `ce_i` low deselects the part. `drive_o` then still follows `oe_i` for two more cycles, and after that it is low.
- R11: After reset the part is deselected, `drive_o` is low and `rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address, used on a start |
| start_cpu_i | input | 1 | Processor start strobe; read beat, gated by ce_i |
| start_ctl_i | input | 1 | Controller start strobe; deselects when ce_i is low |
| ce_i | input | 1 | Chip enable |
| oe_i | input | 1 | Output enable (asynchronous) |
| adv_i | input | 1 | Burst advance |
| mode_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| gw_i | input | 1 | Global write, all lanes |
| bwe_i | input | 1 | Byte-write enable |
| bw_i | input | 4 | Per-lane write select, bit k selects byte k |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| drive_o | output | 1 | Bus drive enable |

## Verification
The assertions expect that `mode_i` does not change the order of a burst already under way, because the order is latched at the start. They also expect that the two strobes are never used to open a processor read and a controller write in the same cycle. The bench drives inputs one time unit after each rising edge and changes `mode_i` only on start beats. It keeps every address inside a fully written memory, so that no read returns an unknown value. The bench keeps a shadow memory that it updates lane by lane from the requirements. It predicts every burst address arithmetically over all start offsets, both orders and both strobes.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  localparam int unsigned LANES  = 4;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned WORD_W = LANES * LANE_W;

  typedef logic [LANES-1:0] lane_mask_t;

  // low address bits of beat n
  function automatic logic [1:0] beat_lo(input logic [1:0] base, input logic [1:0] n,
                                         input logic interleave);
    return interleave ? (base ^ n) : (base + n);
  endfunction
endpackage

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic              mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] beat_addr_o
);
  import burst_sram_pkg::*;

  logic [ADDR_W-1:0] base_q, base_eff;
  logic [1:0]        off_q, off_d;
  logic              mode_q, mode_eff;

  always_comb begin
    base_eff = load_i ? addr_i : base_q;
    mode_eff = load_i ? mode_i : mode_q;
    off_d    = load_i ? 2'd0 : (step_i ? off_q + 2'd1 : off_q);
    beat_addr_o = {base_eff[ADDR_W-1:2], beat_lo(base_eff[1:0], off_d, mode_eff)};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      off_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      base_q <= base_eff;
      off_q  <= off_d;
      mode_q <= mode_eff;
    end
  end
endmodule

// File: rtl/burst_sram_mem.sv
module burst_sram_mem #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [LANES-1:0]         we_i,
  input  logic                     re_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [LANES*LANE_W-1:0]  wdata_i,
  output logic [LANES*LANE_W-1:0]  rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk_i) begin
      if (we_i[l]) mem[addr_i] <= wdata_i[l*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   rd_q <= '0;
      else if (re_i) rd_q <= mem[addr_i];
    end

    assign rdata_o[l*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/burst_sram_drv.sv
module burst_sram_drv #(
  parameter int unsigned TAIL = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic oe_i,
  output logic drive_o
);
  localparam int unsigned CNT_W = $clog2(TAIL + 1);
  localparam logic [CNT_W-1:0] TAIL_V = CNT_W'(TAIL);

  logic [CNT_W-1:0] tail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             tail_q <= '0;
    else if (sel_i)          tail_q <= TAIL_V;
    else if (tail_q != '0)   tail_q <= tail_q - 1'b1;
  end

  assign drive_o = oe_i && (sel_i || tail_q != '0);
endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DESEL_HOLD = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              start_cpu_i,
  input  logic              start_ctl_i,
  input  logic              ce_i,
  input  logic              oe_i,
  input  logic              adv_i,
  input  logic              mode_i,
  input  logic              gw_i,
  input  logic              bwe_i,
  input  logic [3:0]        bw_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              drive_o
);
  import burst_sram_pkg::*;

  logic       cpu_go, ctl_go, desel, cont, access, wr_req;
  logic       sel_q;
  lane_mask_t wr_lanes, lane_we;
  logic [ADDR_W-1:0] beat_addr, acc_addr;
  logic       acc_v, acc_wr;
  lane_mask_t acc_lanes;
  logic [WORD_W-1:0] acc_wdata;

  // processor strobe wins when both are present
  assign cpu_go = start_cpu_i && ce_i;
  assign ctl_go = start_ctl_i && !cpu_go && ce_i;
  assign desel  = start_ctl_i && !cpu_go && !ce_i;
  assign cont   = sel_q && !start_ctl_i && !cpu_go;
  assign access = cpu_go || ctl_go || cont;

  assign wr_req   = !cpu_go && (gw_i || (bwe_i && (bw_i != '0)));
  assign wr_lanes = gw_i ? '1 : bw_i;

  burst_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cpu_go || ctl_go),
    .step_i     (cont && adv_i),
    .mode_i     (mode_i),
    .addr_i     (addr_i),
    .beat_addr_o(beat_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q     <= 1'b0;
      acc_v     <= 1'b0;
      acc_wr    <= 1'b0;
      acc_lanes <= '0;
      acc_addr  <= '0;
      acc_wdata <= '0;
    end else begin
      if (cpu_go || ctl_go) sel_q <= 1'b1;
      else if (desel)       sel_q <= 1'b0;
      acc_v <= access;
      if (access) begin
        acc_wr    <= wr_req;
        acc_lanes <= wr_lanes;
        acc_addr  <= beat_addr;
        acc_wdata <= wdata_i;
      end
    end
  end

  assign lane_we = (acc_v && acc_wr) ? acc_lanes : '0;

  burst_sram_mem #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (lane_we),
    .re_i   (acc_v && !acc_wr),
    .addr_i (acc_addr),
    .wdata_i(acc_wdata),
    .rdata_o(rdata_o)
  );

  burst_sram_drv #(.TAIL(DESEL_HOLD)) u_drv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (sel_q),
    .oe_i   (oe_i),
    .drive_o(drive_o)
  );
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              start_cpu_i,
  input logic              start_ctl_i,
  input logic              ce_i,
  input logic              oe_i,
  input logic              adv_i,
  input logic              gw_i,
  input logic              bwe_i,
  input logic [3:0]        bw_i,
  input logic              drive_o,
  input logic              sel_q,
  input logic [3:0]        lane_we,
  input logic [ADDR_W-1:0] acc_addr
);
  p_start_addr_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((start_cpu_i || start_ctl_i) && ce_i) |=> (acc_addr == $past(addr_i)));

  p_cpu_ignored_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_cpu_i && !ce_i && !start_ctl_i && !sel_q) |=> !sel_q);

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q && !start_ctl_i && !(start_cpu_i && ce_i) && !adv_i) |=> (acc_addr == $past(acc_addr)));

  p_gw_all_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gw_i && start_ctl_i && ce_i && !start_cpu_i) |=> (lane_we == 4'hF));

  p_write_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_we != 4'h0) |-> $past(gw_i || (bwe_i && bw_i != 4'h0)));

  p_cpu_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_cpu_i && ce_i) |=> (lane_we == 4'h0));

  p_oe_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> !drive_o);

  p_sel_drive_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((start_cpu_i || start_ctl_i) && ce_i) |=> (drive_o == oe_i));

  p_tail_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q && start_ctl_i && !start_cpu_i && !ce_i) |=> (!sel_q && drive_o == oe_i));
endmodule

bind burst_sram burst_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .start_cpu_i(start_cpu_i),
  .start_ctl_i(start_ctl_i),
  .ce_i       (ce_i),
  .oe_i       (oe_i),
  .adv_i      (adv_i),
  .gw_i       (gw_i),
  .bwe_i      (bwe_i),
  .bw_i       (bw_i),
  .drive_o    (drive_o),
  .sel_q      (sel_q),
  .lane_we    (lane_we),
  .acc_addr   (acc_addr)
);

// File: tb/burst_sram_test.sv
module burst_sram_test;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 0, rst_ni = 0;
  logic [7:0] addr_i;
  logic       start_cpu_i, start_ctl_i, ce_i, oe_i, adv_i, mode_i, gw_i, bwe_i;
  logic [3:0] bw_i;
  logic [31:0] wdata_i, rdata_o;
  logic       drive_o;

  int errors = 0, checks = 0;
  logic [31:0] ref_mem [256];

  burst_sram uut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    addr_i = '0; start_cpu_i = 0; start_ctl_i = 0; ce_i = 1; oe_i = 1; adv_i = 0;
    gw_i = 0; bwe_i = 0; bw_i = '0; wdata_i = '0;
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  function automatic logic [31:0] pat(input logic [7:0] a);
    return {a, ~a, a ^ 8'h5A, a + 8'h33};
  endfunction

  function automatic logic [7:0] ea(input logic [7:0] a, input int n, input bit m);
    logic [1:0] lo;
    lo = m ? (a[1:0] ^ 2'(n)) : (a[1:0] + 2'(n));
    return {a[7:2], lo};
  endfunction

  task automatic rd_single(input logic [7:0] a, input string req);
    idle(); start_ctl_i = 1; addr_i = a; tick();
    idle(); tick();
    chk(rdata_o === ref_mem[a], req, rdata_o, ref_mem[a]);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    idle(); mode_i = 0;
    #3;
    // R11 reset state
    chk(drive_o === 1'b0, "R11 drive", {31'b0, drive_o}, 32'h0);
    chk(rdata_o === 32'h0, "R11 rdata", rdata_o, 32'h0);
    #(2*CLK_PERIOD) rst_ni = 1;
    tick();
    chk(drive_o === 1'b0, "R11 deselected", {31'b0, drive_o}, 32'h0);

    // fill with global writes, byte controls off (R6)
    for (int a = 0; a < 256; a++) begin
      idle(); start_ctl_i = 1; addr_i = 8'(a); gw_i = 1; wdata_i = pat(8'(a));
      tick();
      ref_mem[a] = pat(8'(a));
    end
    idle(); tick();
    for (int a = 0; a < 256; a += 37) rd_single(8'(a), "R6 fill");

    // burst read sweep: R1 R4 R5 R8 R9
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 2; s++)
        for (int o = 0; o < 4; o++) begin
          logic [7:0] a0;
          a0 = 8'(16 + 4*m + o + 8*s);
          for (int n = 0; n < 4; n++) begin
            idle();
            if (n == 0) begin
              addr_i = a0; mode_i = 1'(m);
              if (s == 0) begin start_cpu_i = 1; gw_i = 1; bwe_i = 1; bw_i = 4'hF; end
              else start_ctl_i = 1;
            end else adv_i = 1;
            tick();
            if (n > 0)
              chk(rdata_o === ref_mem[ea(a0, n-1, 1'(m))], m ? "R5 R1 R8 R9 beat" : "R4 R1 R8 R9 beat",
                  rdata_o, ref_mem[ea(a0, n-1, 1'(m))]);
          end
          idle(); tick();
          chk(rdata_o === ref_mem[ea(a0, 3, 1'(m))], m ? "R5 last beat" : "R4 last beat",
              rdata_o, ref_mem[ea(a0, 3, 1'(m))]);
        end
    mode_i = 0;

    // R3 hold without advance: 20,20,20,21
    idle(); start_ctl_i = 1; addr_i = 8'd20; tick();
    idle(); tick();
    chk(rdata_o === ref_mem[20], "R3 beat0", rdata_o, ref_mem[20]);
    idle(); tick();
    chk(rdata_o === ref_mem[20], "R3 hold1", rdata_o, ref_mem[20]);
    idle(); adv_i = 1; tick();
    chk(rdata_o === ref_mem[20], "R3 hold2", rdata_o, ref_mem[20]);
    idle(); tick();
    chk(rdata_o === ref_mem[21], "R3 step", rdata_o, ref_mem[21]);

    // R7 byte writes, every mask
    for (int k = 0; k < 16; k++) begin
      logic [7:0] a;
      a = 8'(64 + k);
      idle(); start_ctl_i = 1; addr_i = a; bwe_i = 1; bw_i = 4'(k); wdata_i = 32'hC3C3_C3C3;
      tick();
      for (int l = 0; l < 4; l++) if (k[l]) ref_mem[a][l*8 +: 8] = 8'hC3;
      rd_single(a, "R7 lane mask");
    end
    // R7 bwe low: no write
    idle(); start_ctl_i = 1; addr_i = 8'd90; bw_i = 4'hF; wdata_i = 32'h0; tick();
    rd_single(8'd90, "R7 bwe low");
    // R7 empty mask: no write
    idle(); start_ctl_i = 1; addr_i = 8'd91; bwe_i = 1; wdata_i = 32'h0; tick();
    rd_single(8'd91, "R7 empty mask");
    // R6 global write overrides partial mask
    idle(); start_ctl_i = 1; addr_i = 8'd92; gw_i = 1; bwe_i = 1; bw_i = 4'h1; wdata_i = 32'h1234_5678; tick();
    ref_mem[92] = 32'h1234_5678;
    rd_single(8'd92, "R6 override");

    // R8 R5 burst write with interleave from 130: 130,131,128,129
    for (int n = 0; n < 4; n++) begin
      idle(); gw_i = 1; wdata_i = 32'hBEEF_0000 + n;
      if (n == 0) begin start_ctl_i = 1; addr_i = 8'd130; mode_i = 1; end
      else adv_i = 1;
      tick();
      ref_mem[ea(8'd130, n, 1'b1)] = 32'hBEEF_0000 + n;
    end
    mode_i = 0;
    idle(); tick();
    for (int a = 128; a < 132; a++) rd_single(8'(a), "R8 R5 burst write");

    // R2 processor strobe ignored while ce low, burst continues
    idle(); start_ctl_i = 1; addr_i = 8'd8; tick();
    idle(); start_cpu_i = 1; ce_i = 0; addr_i = 8'd200; adv_i = 1; tick();
    chk(rdata_o === ref_mem[8], "R2 beat0", rdata_o, ref_mem[8]);
    idle(); tick();
    chk(rdata_o === ref_mem[9], "R2 continues", rdata_o, ref_mem[9]);

    // R10 deselect tail
    idle(); chk(drive_o === 1'b1, "R10 selected", {31'b0, drive_o}, 32'h1);
    idle(); start_ctl_i = 1; ce_i = 0; tick();
    chk(drive_o === 1'b1, "R10 tail1", {31'b0, drive_o}, 32'h1);
    idle(); ce_i = 0; tick();
    chk(drive_o === 1'b1, "R10 tail2", {31'b0, drive_o}, 32'h1);
    idle(); ce_i = 0; tick();
    chk(drive_o === 1'b0, "R10 off", {31'b0, drive_o}, 32'h0);
    idle(); start_cpu_i = 1; ce_i = 0; addr_i = 8'd5; tick();
    idle(); ce_i = 0; tick();
    chk(drive_o === 1'b0, "R2 stays deselected", {31'b0, drive_o}, 32'h0);
    idle(); start_ctl_i = 1; addr_i = 8'd3; tick();
    chk(drive_o === 1'b1, "R10 reselect", {31'b0, drive_o}, 32'h1);
    oe_i = 0; #1;
    chk(drive_o === 1'b0, "R10 oe low", {31'b0, drive_o}, 32'h0);
    oe_i = 1; tick();
    chk(rdata_o === ref_mem[3], "R9 after reselect", rdata_o, ref_mem[3]);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule